// File: doc/BRIEF.md
# Multi-Device Serial Bit Interleaver

This block lets several slow serial storage devices that rotate in lockstep look like one faster device. Each device delivers one data bit per device bit period, together with a bit from its defect map that says whether that bit position holds a usable loop. On every device bit strobe the block captures all N data bits into one register and the N matching map bits into a second register. It then sends both out as a single serial data stream and a single serial mask stream, one device after another. The mask therefore stays aligned with the data bit by bit. Downstream logic handles the merged pair exactly as it would handle one device, so a bad loop costs one bit and not a whole byte. N can be any count and need not match a byte or word width.

A companion write path works the other way. It collects N serial bits from an outgoing stream and hands them to the devices in parallel on the next strobe. Positions that the defect map marks as unusable are written as zero.

Both serial sides are valid/ready streams. On the read side the devices cannot be stalled. Back-pressure from the consumer only holds the current bit, and the consumer must take all N bits before the next strobe, or the bits it has not taken are lost. On the write side `wr_ready` drops once N bits are collected, and it stays low until a strobe hands those bits to the devices.

Top module: `bitstream_interleaver`

## Requirements
- R1: After reset, `ser_valid` is 0, `wr_ready` is 1, `dev_wr_en` is 0 and `dev_wr_bits` is all zero.
- R2: A `dev_strobe` cycle captures `dev_rd_bits` and `loop_good`. From the next cycle on, `ser_valid` is 1 with N bits pending.
- R3: The pending bits leave in device order: bit 0 (device 0) first and bit N-1 last. `ser_mask` always carries the `loop_good` bit of the same device as `ser_data`.
- R4: A bit advances only on a cycle with `ser_valid` and `ser_ready` both 1. While `ser_ready` is 0, `ser_data` and `ser_mask` hold their values.
- R5: Once N bits have been accepted, `ser_valid` stays 0 until the next strobe.
- R6: A strobe replaces any bits still pending with the new capture. It takes priority over a handshake in the same cycle.
- R7: `wr_ready` is 1 exactly while fewer than N bits are collected. The k-th accepted bit (counting from 0) is destined for device k.
- R8: A strobe that finds N bits collected sets `dev_wr_en` to 1, drives the collected word on `dev_wr_bits` and empties the collection. Both outputs hold until the next strobe.
- R9: `loop_good` bit k = 1 marks device k's current position as usable. Where it is 0, the bit written to `dev_wr_bits[k]` is 0.
- R10: A strobe that finds fewer than N bits collected sets `dev_wr_en` to 0 and `dev_wr_bits` to zero. It keeps the partial collection, and collection continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_strobe | input | 1 | One-cycle pulse per device bit period |
| dev_rd_bits | input | N | Bit read from each device, bit k = device k |
| loop_good | input | N | Defect-map bit per device, 1 = usable position |
| ser_valid | output | 1 | Merged read stream has a bit |
| ser_ready | input | 1 | Consumer takes the current bit |
| ser_data | output | 1 | Merged serial data bit |
| ser_mask | output | 1 | Merged serial mask bit, aligned with ser_data |
| wr_valid | input | 1 | Outgoing serial bit offered |
| wr_ready | output | 1 | Collector accepts a bit |
| wr_bit | input | 1 | Outgoing serial data bit |
| dev_wr_bits | output | N | Parallel bits for the devices, bit k = device k |
| dev_wr_en | output | 1 | dev_wr_bits carries a complete word for this period |

## Verification
The bench builds the block with N = 5. That width is not a divisor of a byte, so the order and alignment checks cannot pass by accident of a power-of-two width. It runs strobe periods longer than N, exactly N, and shorter than N. The short period brings within reach the overrun case, where pending bits are discarded, and a strobe that lands on the same cycle as a handshake. Mask patterns of all ones, all zeros and random values exercise the zeroing of unusable positions. Throttled read and write handshakes exercise back-pressure holds and writes left partial at a strobe.

// File: rtl/interleave_pkg.sv
package interleave_pkg;
  function automatic int cnt_w(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/stream_merge_rd.sv
module stream_merge_rd #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [N-1:0] par_data,
  input  logic [N-1:0] par_mask,
  output logic         s_valid,
  input  logic         s_ready,
  output logic         s_data,
  output logic         s_mask
);
  localparam int CW = interleave_pkg::cnt_w(N);

  logic [N-1:0]  dsh, msh;
  logic [CW-1:0] left;
  logic          take;

  assign take    = s_valid && s_ready;
  assign s_valid = (left != '0);
  assign s_data  = dsh[0];
  assign s_mask  = msh[0];

  // strobe has priority: a reload discards unsent bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsh  <= '0;
      msh  <= '0;
      left <= '0;
    end else if (strobe) begin
      dsh  <= par_data;
      msh  <= par_mask;
      left <= CW'(N);
    end else if (take) begin
      dsh  <= dsh >> 1;
      msh  <= msh >> 1;
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/stream_spread_wr.sv
module stream_spread_wr #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [N-1:0] par_mask,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic         s_data,
  output logic [N-1:0] par_data,
  output logic         par_en
);
  localparam int CW = interleave_pkg::cnt_w(N);

  logic [N-1:0]  fill;
  logic [CW-1:0] fc;
  logic          full, take;

  assign full    = (fc == CW'(N));
  assign s_ready = !full;
  assign take    = s_valid && s_ready;

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      fill[g] <= 1'b0;
      else if (take && fc == CW'(g))   fill[g] <= s_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fc <= '0;
    end else if (strobe && full) begin
      fc <= '0;
    end else if (take) begin
      fc <= fc + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_data <= '0;
      par_en   <= 1'b0;
    end else if (strobe) begin
      par_data <= full ? (fill & par_mask) : '0;
      par_en   <= full;
    end
  end
endmodule

// File: rtl/bitstream_interleaver.sv
module bitstream_interleaver #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dev_strobe,
  input  logic [N-1:0] dev_rd_bits,
  input  logic [N-1:0] loop_good,
  output logic         ser_valid,
  input  logic         ser_ready,
  output logic         ser_data,
  output logic         ser_mask,
  input  logic         wr_valid,
  output logic         wr_ready,
  input  logic         wr_bit,
  output logic [N-1:0] dev_wr_bits,
  output logic         dev_wr_en
);
  stream_merge_rd #(.N(N)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (dev_strobe),
    .par_data (dev_rd_bits),
    .par_mask (loop_good),
    .s_valid  (ser_valid),
    .s_ready  (ser_ready),
    .s_data   (ser_data),
    .s_mask   (ser_mask)
  );

  stream_spread_wr #(.N(N)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (dev_strobe),
    .par_mask (loop_good),
    .s_valid  (wr_valid),
    .s_ready  (wr_ready),
    .s_data   (wr_bit),
    .par_data (dev_wr_bits),
    .par_en   (dev_wr_en)
  );
endmodule

// File: rtl/bitstream_interleaver_chk.sv
module bitstream_interleaver_chk #(
  parameter int N = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic         dev_strobe,
  input logic [N-1:0] loop_good,
  input logic         ser_valid,
  input logic         ser_ready,
  input logic         ser_data,
  input logic         ser_mask,
  input logic         wr_valid,
  input logic         wr_ready,
  input logic [N-1:0] dev_wr_bits,
  input logic         dev_wr_en
);
  localparam int CW = interleave_pkg::cnt_w(N);

  logic [CW-1:0] pend, coll;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      coll <= '0;
    end else begin
      if (dev_strobe)                 pend <= CW'(N);
      else if (ser_valid && ser_ready) pend <= pend - 1'b1;
      if (dev_strobe && coll == CW'(N)) coll <= '0;
      else if (wr_valid && wr_ready)    coll <= coll + 1'b1;
    end
  end

  AST_LOAD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    dev_strobe |=> ser_valid); // R2

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_valid && !ser_ready && !dev_strobe) |=>
      (ser_valid && $stable(ser_data) && $stable(ser_mask))); // R4

  AST_DRAIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid == (pend != '0)); // R5

  AST_WR_READY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready == (coll < CW'(N))); // R7

  AST_WR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    dev_strobe |=> ((dev_wr_bits & ~$past(loop_good)) == '0)); // R9

  AST_WR_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_strobe && wr_ready) |=> (!dev_wr_en && dev_wr_bits == '0)); // R10

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_strobe |=> ($stable(dev_wr_en) && $stable(dev_wr_bits))); // R8
endmodule

bind bitstream_interleaver bitstream_interleaver_chk #(.N(N)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dev_strobe  (dev_strobe),
  .loop_good   (loop_good),
  .ser_valid   (ser_valid),
  .ser_ready   (ser_ready),
  .ser_data    (ser_data),
  .ser_mask    (ser_mask),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .dev_wr_bits (dev_wr_bits),
  .dev_wr_en   (dev_wr_en)
);

// File: tb/tb_bitstream_interleaver.sv
module tb_bitstream_interleaver;
  localparam int N = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         dev_strobe = 1'b0;
  logic [N-1:0] dev_rd_bits = '0;
  logic [N-1:0] loop_good = '0;
  logic         ser_valid, ser_data, ser_mask;
  logic         ser_ready = 1'b0;
  logic         wr_valid = 1'b0, wr_bit = 1'b0;
  logic         wr_ready;
  logic [N-1:0] dev_wr_bits;
  logic         dev_wr_en;

  always #5 clk = ~clk;

  bitstream_interleaver #(.N(N)) dut (.*);

  int nchk = 0, nfail = 0;
  bit running = 0;
  int period = 8, rdy_pct = 100, wr_pct = 100, mask_mode = 0, cyc = 0;

  // behavioural reference
  bit           qd[$], qm[$], wq[$];
  logic [N-1:0] exp_wbits = '0;
  bit           exp_wen = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      qd.delete(); qm.delete(); wq.delete();
      exp_wbits = '0; exp_wen = 0;
    end else begin
      int pre;
      bit hs;
      if (dev_strobe) begin
        qd.delete(); qm.delete();
        for (int k = 0; k < N; k++) begin
          qd.push_back(dev_rd_bits[k]);
          qm.push_back(loop_good[k]);
        end
      end else if (qd.size() > 0 && ser_ready) begin
        void'(qd.pop_front()); void'(qm.pop_front());
      end
      pre = wq.size();
      hs  = wr_valid && (pre < N);
      if (dev_strobe && pre == N) begin
        exp_wbits = '0;
        for (int k = 0; k < N; k++) exp_wbits[k] = wq[k] & loop_good[k];
        exp_wen = 1;
        wq.delete();
      end else begin
        if (dev_strobe) begin exp_wbits = '0; exp_wen = 0; end
        if (hs) wq.push_back(wr_bit);
      end
    end
  end

  always @(negedge clk) begin
    if (running) begin
      chk("R2 R5 ser_valid", 32'(ser_valid), 32'(qd.size() > 0));
      if (qd.size() > 0) begin
        chk("R3 R4 R6 ser_data", 32'(ser_data), 32'(qd[0]));
        chk("R3 ser_mask", 32'(ser_mask), 32'(qm[0]));
      end
      chk("R7 wr_ready", 32'(wr_ready), 32'(wq.size() < N));
      chk("R8 R10 dev_wr_en", 32'(dev_wr_en), 32'(exp_wen));
      chk("R8 R9 R10 dev_wr_bits", 32'(dev_wr_bits), 32'(exp_wbits));
      cyc++;
      dev_strobe  <= (cyc % period == 0);
      dev_rd_bits <= N'($urandom);
      loop_good   <= (mask_mode == 0) ? N'($urandom) :
                     (mask_mode == 1) ? {N{1'b1}} : '0;
      ser_ready   <= ($urandom % 100) < rdy_pct;
      wr_valid    <= ($urandom % 100) < wr_pct;
      wr_bit      <= 1'($urandom);
    end
  end

  task automatic phase(input int p, input int r, input int w, input int m, input int n);
    period = p; rdy_pct = r; wr_pct = w; mask_mode = m;
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1 ser_valid", 32'(ser_valid), 0);
    chk("R1 wr_ready", 32'(wr_ready), 1);
    chk("R1 dev_wr_en", 32'(dev_wr_en), 0);
    chk("R1 dev_wr_bits", 32'(dev_wr_bits), 0);
    @(posedge clk);
    running = 1;
    phase(8, 100, 100, 1, 300);   // R2 R3 R8 steady flow, all usable
    phase(12, 50, 40, 0, 600);    // R4 R7 R10 throttled
    phase(4, 100, 100, 0, 300);   // R6 overrun, strobe before drain
    phase(5, 100, 100, 2, 300);   // R6 R9 coincident strobe, all masked
    phase(9, 30, 70, 0, 600);     // R4 R5 mixed
    running = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #200000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule